// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block chooses the next micro-address for a microprogrammed control unit that serves a simple single-bus processor. It holds a 10-bit micro-program counter and reads a 1024-entry control store on the clock edge that loads that counter. It then presents the encoded fields of the current microinstruction so that a separate decoder can drive the data path. The data path, the field decoders and the macro-instruction memory are outside the block.

Each cycle the current microinstruction sets the next address. A two-bit source select picks the incremented counter, the decode-table start address, an external address or the word's own 10-bit target. A three-bit condition code gates that choice against the data-path flags. A set finish bit sends control back to the shared fetch routine. Reset and exception requests, both already synchronous to the clock, override all of this. One condition code is a case branch: it ORs a two-bit selector into the target and so reaches one of four routines in one clock. The control store is sparse, and its contents come in as parameters.

Top module: `usq_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the counter loads 100. In the next cycle `upc_o` is 100 and the field outputs show the word stored at 100. `rst` takes precedence over `exc_req`.
- R2: When `exc_req` is high and `rst` is low, the next address is 0. This takes precedence over the finish bit and over branching.
- R3: A source select of 00 gives the next address as the current address plus one, wrapping from 1023 to 0. The same address follows whenever a condition is not met.
- R4: Source 01 with a met condition loads `decode_addr`.
- R5: Source 10 with a met condition loads `ext_addr`.
- R6: Condition code 000 is always met. Code 001 is met when `flag_con` is 0, code 010 when `flag_con` is 1, code 011 when `flag_zero` is 1, and code 100 when `flag_neg` is 1. Source 11 with a met condition loads the 10-bit target field as an absolute address.
- R7: Codes 101 and 111 are never met, so the next address is the current address plus one.
- R8: When the finish bit is 1, the next address is 100 whatever the source and condition fields say.
- R9: Code 110 is always met. With source 11 it loads the target ORed with `case_sel` shifted into bits 3:2.
- R10: A word is packed from bit 30 down as source select [30:29], condition [28:26], finish [25], out-gate [24:22], in-gate [21:19], misc [18:16], register select [15:14], ALU [13:10] and target [9:0]. Each field output equals its slice of the word at `upc_o`, during the same cycle. Addresses not listed in the program read as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Synchronized exception request |
| flag_con | input | 1 | Data-path branch condition flag |
| flag_zero | input | 1 | Data-path counter-is-zero flag |
| flag_neg | input | 1 | Data-path negative flag |
| decode_addr | input | 10 | Start address of the current opcode's routine |
| ext_addr | input | 10 | External jump address |
| case_sel | input | 2 | Selector for the case branch |
| upc_o | output | 10 | Current micro-address |
| f_src | output | 2 | Next-address source select |
| f_brc | output | 3 | Condition code |
| f_fin | output | 1 | Finish bit |
| f_og | output | 3 | Out-gate code |
| f_ig | output | 3 | In-gate code |
| f_misc | output | 3 | Miscellaneous control code |
| f_rsel | output | 2 | Register gate select |
| f_alu | output | 4 | ALU function code |
| f_target | output | 10 | Target address field |

## Verification
The test program gives each condition code its own address. Each of those addresses is run under all eight combinations of the three flags, so a swapped or inverted flag shows up as the wrong trace. A case-branch word is visited with every selector value, which separates the OR-in from a plain target load. Mid-routine exceptions, reset together with exception, an exception on a finishing word, and a jump to the top of the address space test the priorities and the wrap. A scoreboard compares both the address trace and the field outputs against an independent model, so a misaligned field shows up even when the address is correct.

// File: rtl/usq_pkg.sv
package usq_pkg;

    localparam int AW       = 10;
    localparam int DEPTH    = 1 << AW;
    localparam int SRC_W    = 2;
    localparam int BRC_W    = 3;
    localparam int OG_W     = 3;
    localparam int IG_W     = 3;
    localparam int MISC_W   = 3;
    localparam int RSEL_W   = 2;
    localparam int ALU_W    = 4;
    localparam int UW       = SRC_W + BRC_W + 1 + OG_W + IG_W + MISC_W + RSEL_W + ALU_W + AW;
    localparam int CASE_W   = 2;
    localparam int CASE_LSB = 2;

    typedef logic [AW-1:0] uaddr_t;

    typedef enum logic [SRC_W-1:0] {
        SRC_SEQ    = 2'b00,
        SRC_DECODE = 2'b01,
        SRC_EXT    = 2'b10,
        SRC_TARGET = 2'b11
    } src_e;

    typedef enum logic [BRC_W-1:0] {
        BC_ALWAYS = 3'b000,
        BC_CON_LO = 3'b001,
        BC_CON_HI = 3'b010,
        BC_ZERO   = 3'b011,
        BC_NEG    = 3'b100,
        BC_NEVER  = 3'b101,
        BC_CASE   = 3'b110,
        BC_SPARE  = 3'b111
    } brc_e;

    typedef struct packed {
        src_e               src;
        brc_e               brc;
        logic               fin;
        logic [OG_W-1:0]    og;
        logic [IG_W-1:0]    ig;
        logic [MISC_W-1:0]  misc;
        logic [RSEL_W-1:0]  rsel;
        logic [ALU_W-1:0]   alu;
        uaddr_t             target;
    } uword_t;

    localparam uaddr_t FETCH_ENTRY = 10'd100;
    localparam uaddr_t EXC_ENTRY   = 10'd0;

    function automatic uaddr_t seq_addr(input uaddr_t a);
        return a + uaddr_t'(1);
    endfunction

    function automatic uaddr_t case_target(input uaddr_t base, input logic [CASE_W-1:0] sel);
        return base | (uaddr_t'(sel) << CASE_LSB);
    endfunction

    function automatic logic [UW-1:0] pack_word(input src_e s, input brc_e b, input logic f,
                                                input logic [ALU_W-1:0] alu, input uaddr_t t);
        uword_t w;
        w        = '0;
        w.src    = s;
        w.brc    = b;
        w.fin    = f;
        w.alu    = alu;
        w.target = t;
        return w;
    endfunction

    localparam int DEF_LEN = 6;

    localparam logic [DEF_LEN-1:0][AW-1:0] DEF_ADDR = {
        10'd202, 10'd201, 10'd200, 10'd102, 10'd101, 10'd100
    };

    localparam logic [DEF_LEN-1:0][UW-1:0] DEF_WORD = {
        pack_word(SRC_SEQ,    BC_NEVER,  1'b1, 4'd0, 10'd0),
        pack_word(SRC_SEQ,    BC_NEVER,  1'b0, 4'd1, 10'd0),
        pack_word(SRC_SEQ,    BC_NEVER,  1'b0, 4'd0, 10'd0),
        pack_word(SRC_DECODE, BC_ALWAYS, 1'b0, 4'd0, 10'd0),
        pack_word(SRC_SEQ,    BC_NEVER,  1'b0, 4'd0, 10'd0),
        pack_word(SRC_SEQ,    BC_NEVER,  1'b0, 4'd3, 10'd0)
    };

endpackage

// File: rtl/usq_store.sv
module usq_store import usq_pkg::*; #(
    parameter int PROG_LEN = DEF_LEN,
    parameter logic [PROG_LEN-1:0][AW-1:0] PROG_ADDR = DEF_ADDR,
    parameter logic [PROG_LEN-1:0][UW-1:0] PROG_WORD = DEF_WORD
) (
    input  logic   clk,
    input  uaddr_t rd_addr,
    output uword_t word_q
);

    logic [PROG_LEN-1:0] hit;
    logic [UW-1:0]       rd_word;

    for (genvar g = 0; g < PROG_LEN; g++) begin : g_match
        assign hit[g] = (PROG_ADDR[g] == rd_addr);
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < PROG_LEN; i++) begin
            if (hit[i]) rd_word = rd_word | PROG_WORD[i];
        end
    end

    always_ff @(posedge clk) begin
        word_q <= uword_t'(rd_word);
    end

endmodule

// File: rtl/usq_cond.sv
module usq_cond import usq_pkg::*; (
    input  brc_e brc,
    input  logic flag_con,
    input  logic flag_zero,
    input  logic flag_neg,
    output logic take,
    output logic is_case
);

    always_comb begin
        is_case = 1'b0;
        unique case (brc)
            BC_ALWAYS: take = 1'b1;
            BC_CON_LO: take = ~flag_con;
            BC_CON_HI: take = flag_con;
            BC_ZERO:   take = flag_zero;
            BC_NEG:    take = flag_neg;
            BC_CASE: begin
                take    = 1'b1;
                is_case = 1'b1;
            end
            default:   take = 1'b0;
        endcase
    end

endmodule

// File: rtl/usq_next.sv
module usq_next import usq_pkg::*; (
    input  logic              rst,
    input  logic              exc_req,
    input  logic              fin,
    input  src_e              src,
    input  uaddr_t            target,
    input  logic              take,
    input  logic              is_case,
    input  uaddr_t            upc,
    input  uaddr_t            decode_addr,
    input  uaddr_t            ext_addr,
    input  logic [CASE_W-1:0] case_sel,
    output uaddr_t            nxt
);

    uaddr_t inc_addr;
    uaddr_t jump_addr;

    assign inc_addr = seq_addr(upc);

    always_comb begin
        unique case (src)
            SRC_SEQ:    jump_addr = inc_addr;
            SRC_DECODE: jump_addr = decode_addr;
            SRC_EXT:    jump_addr = ext_addr;
            default:    jump_addr = is_case ? case_target(target, case_sel) : target;
        endcase
    end

    always_comb begin
        if (rst)          nxt = FETCH_ENTRY;
        else if (exc_req) nxt = EXC_ENTRY;
        else if (fin)     nxt = FETCH_ENTRY;
        else if (take)    nxt = jump_addr;
        else              nxt = inc_addr;
    end

endmodule

// File: rtl/usq_sequencer.sv
module usq_sequencer import usq_pkg::*; #(
    parameter int PROG_LEN = DEF_LEN,
    parameter logic [PROG_LEN-1:0][AW-1:0] PROG_ADDR = DEF_ADDR,
    parameter logic [PROG_LEN-1:0][UW-1:0] PROG_WORD = DEF_WORD
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        exc_req,
    input  logic        flag_con,
    input  logic        flag_zero,
    input  logic        flag_neg,
    input  logic [9:0]  decode_addr,
    input  logic [9:0]  ext_addr,
    input  logic [1:0]  case_sel,
    output logic [9:0]  upc_o,
    output logic [1:0]  f_src,
    output logic [2:0]  f_brc,
    output logic        f_fin,
    output logic [2:0]  f_og,
    output logic [2:0]  f_ig,
    output logic [2:0]  f_misc,
    output logic [1:0]  f_rsel,
    output logic [3:0]  f_alu,
    output logic [9:0]  f_target
);

    uaddr_t upc_q;
    uaddr_t upc_d;
    uword_t cur;
    logic   take;
    logic   is_case;

    usq_store #(
        .PROG_LEN  (PROG_LEN),
        .PROG_ADDR (PROG_ADDR),
        .PROG_WORD (PROG_WORD)
    ) u_store (
        .clk     (clk),
        .rd_addr (upc_d),
        .word_q  (cur)
    );

    usq_cond u_cond (
        .brc       (cur.brc),
        .flag_con  (flag_con),
        .flag_zero (flag_zero),
        .flag_neg  (flag_neg),
        .take      (take),
        .is_case   (is_case)
    );

    usq_next u_next (
        .rst         (rst),
        .exc_req     (exc_req),
        .fin         (cur.fin),
        .src         (cur.src),
        .target      (cur.target),
        .take        (take),
        .is_case     (is_case),
        .upc         (upc_q),
        .decode_addr (decode_addr),
        .ext_addr    (ext_addr),
        .case_sel    (case_sel),
        .nxt         (upc_d)
    );

    always_ff @(posedge clk) begin
        if (rst) upc_q <= FETCH_ENTRY;
        else     upc_q <= upc_d;
    end

    assign upc_o    = upc_q;
    assign f_src    = cur.src;
    assign f_brc    = cur.brc;
    assign f_fin    = cur.fin;
    assign f_og     = cur.og;
    assign f_ig     = cur.ig;
    assign f_misc   = cur.misc;
    assign f_rsel   = cur.rsel;
    assign f_alu    = cur.alu;
    assign f_target = cur.target;

endmodule

// File: rtl/usq_sequencer_chk.sv
module usq_sequencer_chk import usq_pkg::*; (
    input logic       clk,
    input logic       rst,
    input logic       exc_req,
    input logic [9:0] ext_addr,
    input logic [1:0] case_sel,
    input logic [9:0] upc_o,
    input logic [1:0] f_src,
    input logic [2:0] f_brc,
    input logic       f_fin,
    input logic [9:0] f_target
);

    // R1: reset loads the fetch entry
    assert_reset_entry_R1: assert property (@(posedge clk)
        rst |=> upc_o == FETCH_ENTRY);

    // R2: exception vector
    assert_exc_vector_R2: assert property (@(posedge clk) disable iff (rst)
        exc_req |=> upc_o == EXC_ENTRY);

    // R8: finish bit returns to fetch
    assert_fin_fetch_R8: assert property (@(posedge clk) disable iff (rst)
        (!exc_req && f_fin) |=> upc_o == FETCH_ENTRY);

    // R3: sequential source increments with wrap
    assert_seq_inc_R3: assert property (@(posedge clk) disable iff (rst)
        (!exc_req && !f_fin && f_src == 2'b00) |=> upc_o == 10'($past(upc_o) + 10'd1));

    // R7: never-met codes fall through
    assert_no_branch_R7: assert property (@(posedge clk) disable iff (rst)
        (!exc_req && !f_fin && (f_brc == 3'b101 || f_brc == 3'b111))
        |=> upc_o == 10'($past(upc_o) + 10'd1));

    // R5: unconditional external jump
    assert_ext_jump_R5: assert property (@(posedge clk) disable iff (rst)
        (!exc_req && !f_fin && f_src == 2'b10 && f_brc == 3'b000) |=> upc_o == $past(ext_addr));

    // R9: case branch ORs the selector into bits 3:2
    assert_case_branch_R9: assert property (@(posedge clk) disable iff (rst)
        (!exc_req && !f_fin && f_src == 2'b11 && f_brc == 3'b110)
        |=> upc_o == ($past(f_target) | {6'd0, $past(case_sel), 2'b00}));

endmodule

bind usq_sequencer usq_sequencer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .exc_req  (exc_req),
    .ext_addr (ext_addr),
    .case_sel (case_sel),
    .upc_o    (upc_o),
    .f_src    (f_src),
    .f_brc    (f_brc),
    .f_fin    (f_fin),
    .f_target (f_target)
);

// File: tb/usq_sequencer_bench.sv
`timescale 1ns/1ps
module usq_sequencer_bench;

    localparam int N = 23;
    typedef logic [N-1:0][9:0]  addr_arr_t;
    typedef logic [N-1:0][30:0] word_arr_t;

    function automatic logic [30:0] mk(input int a, input int s, input int b, input int f, input int t);
        logic [14:0] fill;
        fill = {5'b10110, 10'(a)};
        return {2'(s), 3'(b), 1'(f), fill, 10'(t)};
    endfunction

    function automatic int pa(input int i);
        case (i)
            0: return 100;  1: return 101;  2: return 102;
            3: return 200;  4: return 201;  5: return 202;
            6: return 0;
            15: return 310; 16: return 320; 17: return 330; 18: return 340;
            19: return 384; 20: return 388; 21: return 392; 22: return 396;
            default: return 300 + (i - 7);
        endcase
    endfunction

    function automatic logic [30:0] pw(input int i);
        int a;
        a = pa(i);
        case (i)
            0, 1, 3, 4: return mk(a, 0, 5, 0, 0);
            2:  return mk(a, 1, 0, 0, 0);
            5:  return mk(a, 3, 0, 1, 300);
            6:  return mk(a, 3, 0, 0, 100);
            7:  return mk(a, 3, 1, 0, 310);
            8:  return mk(a, 3, 2, 0, 320);
            9:  return mk(a, 3, 3, 0, 330);
            10: return mk(a, 3, 4, 0, 340);
            11: return mk(a, 3, 5, 0, 350);
            12: return mk(a, 2, 0, 0, 0);
            13: return mk(a, 3, 6, 0, 384);
            14: return mk(a, 3, 7, 0, 360);
            default: return mk(a, 0, 0, 1, 0);
        endcase
    endfunction

    function automatic addr_arr_t all_addr();
        addr_arr_t r;
        for (int i = 0; i < N; i++) r[i] = 10'(pa(i));
        return r;
    endfunction

    function automatic word_arr_t all_word();
        word_arr_t r;
        for (int i = 0; i < N; i++) r[i] = pw(i);
        return r;
    endfunction

    localparam addr_arr_t TB_ADDR = all_addr();
    localparam word_arr_t TB_WORD = all_word();

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       exc_req = 1'b0;
    logic       flag_con = 1'b0, flag_zero = 1'b0, flag_neg = 1'b0;
    logic [9:0] decode_addr = '0, ext_addr = '0;
    logic [1:0] case_sel = '0;
    logic [9:0] upc_o;
    logic [1:0] f_src;
    logic [2:0] f_brc;
    logic       f_fin;
    logic [2:0] f_og, f_ig, f_misc;
    logic [1:0] f_rsel;
    logic [3:0] f_alu;
    logic [9:0] f_target;

    always #10 clk = ~clk;

    usq_sequencer #(.PROG_LEN(N), .PROG_ADDR(TB_ADDR), .PROG_WORD(TB_WORD)) u_usq_sequencer (
        .clk(clk), .rst(rst), .exc_req(exc_req), .flag_con(flag_con), .flag_zero(flag_zero),
        .flag_neg(flag_neg), .decode_addr(decode_addr), .ext_addr(ext_addr), .case_sel(case_sel),
        .upc_o(upc_o), .f_src(f_src), .f_brc(f_brc), .f_fin(f_fin), .f_og(f_og), .f_ig(f_ig),
        .f_misc(f_misc), .f_rsel(f_rsel), .f_alu(f_alu), .f_target(f_target)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [9:0] exp_q[$];
    string      tag_q[$];
    logic [9:0] m_cur = 10'd100;

    function automatic logic [30:0] word_at(input logic [9:0] a);
        for (int i = 0; i < N; i++) if (TB_ADDR[i] == a) return TB_WORD[i];
        return '0;
    endfunction

    // reference next address and the requirement that decides it
    function automatic logic [9:0] ref_next(input logic [9:0] cur, input logic r, input logic e,
                                            input logic c, input logic z, input logic n,
                                            input logic [9:0] dec, input logic [9:0] ext,
                                            input logic [1:0] cs, output string why);
        logic [30:0] w;
        logic [1:0]  s;
        logic [2:0]  b;
        logic        met;
        logic [9:0]  inc;
        w   = word_at(cur);
        s   = w[30:29];
        b   = w[28:26];
        inc = cur + 10'd1;
        if (r) begin why = "R1"; return 10'd100; end
        if (e) begin why = "R2"; return 10'd0; end
        if (w[25]) begin why = "R8"; return 10'd100; end
        case (b)
            3'b000:  met = 1'b1;
            3'b001:  met = !c;
            3'b010:  met = c;
            3'b011:  met = z;
            3'b100:  met = n;
            3'b110:  met = 1'b1;
            default: met = 1'b0;
        endcase
        if (b == 3'b101 || b == 3'b111) begin why = "R7"; return inc; end
        if (b != 3'b000 && b != 3'b110) why = "R6";
        else why = "R3";
        if (!met || s == 2'b00) begin
            if (b == 3'b000 || b == 3'b110) why = "R3";
            return inc;
        end
        if (s == 2'b01) begin why = "R4"; return dec; end
        if (s == 2'b10) begin why = "R5"; return ext; end
        if (b == 3'b110) begin why = "R9"; return w[9:0] | {6'd0, cs, 2'b00}; end
        if (b == 3'b000) why = "R6";
        return w[9:0];
    endfunction

    task automatic step(input logic r, input logic e, input logic [2:0] fl,
                        input logic [9:0] dec, input logic [9:0] ext, input logic [1:0] cs);
        string why;
        logic [9:0] nx;
        @(negedge clk);
        rst = r; exc_req = e;
        flag_con = fl[2]; flag_zero = fl[1]; flag_neg = fl[0];
        decode_addr = dec; ext_addr = ext; case_sel = cs;
        nx = ref_next(m_cur, r, e, fl[2], fl[1], fl[0], dec, ext, cs, why);
        exp_q.push_back(nx);
        tag_q.push_back(why);
        m_cur = nx;
    endtask

    // monitor: compare address trace and field outputs
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                logic [9:0]  ea;
                string       tg;
                logic [30:0] ew, aw;
                ea = exp_q.pop_front();
                tg = tag_q.pop_front();
                total++;
                if (upc_o !== ea) begin
                    bad++;
                    $display("FAIL %s: upc actual=%0d expected=%0d", tg, upc_o, ea);
                end
                ew = word_at(ea);
                aw = {f_src, f_brc, f_fin, f_og, f_ig, f_misc, f_rsel, f_alu, f_target};
                total++;
                if (aw !== ew) begin
                    bad++;
                    $display("FAIL R10: fields at %0d actual=%h expected=%h", ea, aw, ew);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset, then fetch and add routine (R4, R8)
        step(1, 0, 3'b000, 10'd200, 10'd0, 2'd0);
        step(1, 1, 3'b000, 10'd200, 10'd0, 2'd0);   // R1 over R2
        for (int k = 0; k < 7; k++) step(0, 0, 3'(k), 10'd200, 10'd0, 2'd0);
        // R2 exception on a finishing word
        for (int k = 0; k < 10 && m_cur != 10'd202; k++) step(0, 0, 3'b000, 10'd200, 10'd0, 2'd0);
        step(0, 1, 3'b000, 10'd200, 10'd0, 2'd0);
        for (int k = 0; k < 3; k++) step(0, 0, 3'b000, 10'd200, 10'd0, 2'd0);
        // each test word under every flag combination (R3, R5, R6, R7, R9)
        for (int w = 0; w < 8; w++) begin
            for (int f = 0; f < 8; f++) begin
                step(0, 1, 3'(f), 10'(300 + w), 10'(1020 + (f % 4)), 2'(f));
                for (int k = 0; k < 12; k++)
                    step(0, 0, 3'(f), 10'(300 + w), 10'(1020 + (f % 4)), 2'(f));
            end
        end
        // reset mid-routine (R1)
        step(1, 0, 3'b000, 10'd200, 10'd0, 2'd0);
        for (int k = 0; k < 4; k++) step(0, 0, 3'b000, 10'd200, 10'd0, 2'd0);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule